// File: doc/BRIEF.md
# Power-On Configuration Strap Capture and Frequency Select

This block samples a set of dual-use pads while the chip is held in power-on reset and keeps those levels for the rest of operation. During reset the pads are inputs, and resistors on the board set their levels. Once reset is released, the block enables the pad drivers so that the same pins can carry clock outputs. The driver enables open only after the captured value is frozen, so a pin is never driven while it is still being sampled.

Four of the captured bits form a strap frequency code. The fifth bit picks the operating profile: desktop when high, mobile when low. A software override bit chooses between the strap code and a code from the configuration register. The chosen code goes out registered. The strap code is also returned in complemented form, so the serial register file can present it as active-low readback fields.

In mobile mode the profile pad is never turned into an output. It stays an input and works as the active-low request that stops the peripheral-bus clocks.

Top module: `strap_latch_sel`

## Requirements
- R1: While `por_n_i` is low, `pad_oe_o` is 5'b00000 and `fs_sel_o` is 4'h0.
- R2: The value captured is the pad level sampled at the clock edge on which the synchronised reset releases. Pad changes made one cycle before that edge are still taken.
- R3: After the release edge, changes on `pad_i` have no effect on `fs_rb_n_o`, `desktop_o` or the strap-selected `fs_sel_o`.
- R4: `fs_rb_n_o[k]` is the complement of the captured pad bit `k`, for k = 0..3.
- R5: Driver enables stay at 0 for the whole capture window and for `OE_DELAY` (default 2) further clocks. Once set, they stay set until the next reset.
- R6: Pad bit 4 is the profile strap (1 = desktop, 0 = mobile) and appears on `desktop_o`. In desktop mode all five enables rise (5'b11111). In mobile mode enable bit 4 stays 0 (5'b01111).
- R7: In mobile mode after release, `pci_stop_n_o` follows `pad_i[4]`. In desktop mode, and during reset, it is held at 1.
- R8: `fs_sel_o` is updated one clock after its inputs. It takes `sw_fs_i` when `sw_override_i` is 1 and the captured pad bits 3..0 when it is 0.
- R9: The rising edge of `por_n_i` reaches the logic after `SYNC_STAGES` (default 2) clock edges. `fs_sel_o` first loads on the edge after that.
- R10: Driving `por_n_i` low at any time clears the enables and the selected code at once and reopens capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| por_n_i | input | 1 | Power-on reset, active low, asynchronous assert |
| pad_i | input | 5 | Pad input levels: bits 3..0 frequency straps, bit 4 profile strap |
| sw_override_i | input | 1 | 1 selects the software frequency code |
| sw_fs_i | input | 4 | Software frequency code |
| pad_oe_o | output | 5 | Pad driver enables, one per pad |
| fs_sel_o | output | 4 | Active frequency-select code (registered) |
| fs_rb_n_o | output | 4 | Complemented strap frequency bits for readback |
| desktop_o | output | 1 | Captured profile strap |
| pci_stop_n_o | output | 1 | Peripheral clock stop request, active low |

## Verification
The selection register first loads on the clock right after reset release. A software override can arrive in that same cycle. The bench raises the override bit one cycle before that first load and drops it one cycle later. It expects the software code for exactly one cycle and the strap code after that. The bench also changes the pads one cycle before the capture freezes and again right after it, to confirm that the edge is placed correctly.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned FS_W     = 4;
  localparam int unsigned PAD_N    = FS_W + 1;
  localparam int unsigned MODE_IDX = FS_W;

  typedef struct packed {
    logic            desktop;
    logic [FS_W-1:0] fs;
  } strap_t;
endpackage

// File: rtl/strap_por_sync.sv
module strap_por_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic por_n_i,
  output logic rst_sync_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge por_n_i) begin
    if (!por_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_sync_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic             clk_i,
  input  logic             capture_en_i,
  input  logic [PAD_N-1:0] pad_i,
  output strap_t           strap_o
);
  strap_t strap_q;
  strap_t strap_d;

  always_comb begin
    strap_d = strap_q;
    if (capture_en_i) strap_d = strap_t'(pad_i);
  end

  always_ff @(posedge clk_i) begin
    strap_q <= strap_d;
  end

  assign strap_o = strap_q;

  // R3: once capture has closed, the stored straps never move
  p_strap_hold_r3: assert property (@(posedge clk_i) disable iff (capture_en_i)
    !$past(capture_en_i) |-> $stable(strap_q));
endmodule

// File: rtl/strap_fs_sel.sv
module strap_fs_sel
  import strap_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_sync_n_i,
  input  strap_t          strap_i,
  input  logic            sw_override_i,
  input  logic [FS_W-1:0] sw_fs_i,
  output logic [FS_W-1:0] fs_sel_o,
  output logic [FS_W-1:0] fs_rb_n_o
);
  logic [FS_W-1:0] fs_q;
  logic [FS_W-1:0] fs_d;
  logic            load_en;

  always_comb begin
    load_en = rst_sync_n_i;
    fs_d    = sw_override_i ? sw_fs_i : strap_i.fs;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n_i) begin
    if (!rst_sync_n_i)  fs_q <= '0;
    else if (load_en)   fs_q <= fs_d;
  end

  assign fs_sel_o  = fs_q;
  assign fs_rb_n_o = ~strap_i.fs;

  // R8: with override set, the software code appears one clock later
  p_override_r8: assert property (@(posedge clk_i) disable iff (!rst_sync_n_i)
    ($past(rst_sync_n_i) && $past(sw_override_i)) |-> (fs_sel_o == $past(sw_fs_i)));
endmodule

// File: rtl/strap_oe_seq.sv
module strap_oe_seq
  import strap_pkg::*;
#(
  parameter int unsigned OE_DELAY = 2
) (
  input  logic             clk_i,
  input  logic             rst_sync_n_i,
  input  logic             desktop_i,
  output logic [PAD_N-1:0] pad_oe_o
);
  localparam int unsigned CNT_W = $clog2(OE_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OE_DELAY);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             done;

  always_comb begin
    done  = (cnt_q == CNT_LAST);
    cnt_d = done ? cnt_q : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n_i) begin
    if (!rst_sync_n_i) cnt_q <= '0;
    else if (!done)    cnt_q <= cnt_d;
  end

  for (genvar k = 0; k < PAD_N; k++) begin : g_pad_oe
    if (k == MODE_IDX) begin : g_mode_pad
      assign pad_oe_o[k] = done & desktop_i;
    end else begin : g_clk_pad
      assign pad_oe_o[k] = done;
    end
  end

  // R5: enables never fall back while out of reset
  p_oe_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_n_i)
    pad_oe_o[0] |=> pad_oe_o[0]);
endmodule

// File: rtl/strap_latch_sel.sv
module strap_latch_sel
  import strap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OE_DELAY    = 2
) (
  input  logic             clk_i,
  input  logic             por_n_i,
  input  logic [PAD_N-1:0] pad_i,
  input  logic             sw_override_i,
  input  logic [FS_W-1:0]  sw_fs_i,
  output logic [PAD_N-1:0] pad_oe_o,
  output logic [FS_W-1:0]  fs_sel_o,
  output logic [FS_W-1:0]  fs_rb_n_o,
  output logic             desktop_o,
  output logic             pci_stop_n_o
);
  logic   rst_sync_n;
  logic   capture_en;
  strap_t strap;

  strap_por_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i        (clk_i),
    .por_n_i      (por_n_i),
    .rst_sync_n_o (rst_sync_n)
  );

  assign capture_en = ~rst_sync_n;

  strap_capture u_cap (
    .clk_i        (clk_i),
    .capture_en_i (capture_en),
    .pad_i        (pad_i),
    .strap_o      (strap)
  );

  strap_fs_sel u_sel (
    .clk_i         (clk_i),
    .rst_sync_n_i  (rst_sync_n),
    .strap_i       (strap),
    .sw_override_i (sw_override_i),
    .sw_fs_i       (sw_fs_i),
    .fs_sel_o      (fs_sel_o),
    .fs_rb_n_o     (fs_rb_n_o)
  );

  strap_oe_seq #(.OE_DELAY(OE_DELAY)) u_oe (
    .clk_i        (clk_i),
    .rst_sync_n_i (rst_sync_n),
    .desktop_i    (strap.desktop),
    .pad_oe_o     (pad_oe_o)
  );

  assign desktop_o    = rst_sync_n ? strap.desktop : 1'b1;
  assign pci_stop_n_o = (rst_sync_n && !strap.desktop) ? pad_i[MODE_IDX] : 1'b1;

  // R5: no pad driver opens while the capture window is still active
  p_no_drive_in_capture_r5: assert property (@(posedge clk_i) disable iff (!por_n_i)
    capture_en |-> (pad_oe_o == '0));

  // R4: without override, the selected code is the complement of the readback
  p_rb_matches_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    ($past(rst_sync_n) && !$past(sw_override_i)) |-> (fs_sel_o == ~$past(fs_rb_n_o)));
endmodule

// File: tb/strap_latch_sel_tb.sv
module strap_latch_sel_tb_top;
  logic       clk = 1'b0;
  logic       por_n;
  logic [4:0] pad;
  logic       ovr;
  logic [3:0] swfs;
  logic [4:0] pad_oe;
  logic [3:0] fs_sel;
  logic [3:0] fs_rb_n;
  logic       desktop;
  logic       pci_stop_n;

  int cyc = 0;
  int total = 0;
  int fails = 0;

  typedef struct {
    int         due;
    int         sig;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  strap_latch_sel dut_i (
    .clk_i         (clk),
    .por_n_i       (por_n),
    .pad_i         (pad),
    .sw_override_i (ovr),
    .sw_fs_i       (swfs),
    .pad_oe_o      (pad_oe),
    .fs_sel_o      (fs_sel),
    .fs_rb_n_o     (fs_rb_n),
    .desktop_o     (desktop),
    .pci_stop_n_o  (pci_stop_n)
  );

  // signal codes: 0 pad_oe, 1 fs_sel, 2 fs_rb_n, 3 pci_stop_n, 4 desktop
  function automatic logic [7:0] observe(int sig);
    case (sig)
      0: return {3'b0, pad_oe};
      1: return {4'b0, fs_sel};
      2: return {4'b0, fs_rb_n};
      3: return {7'b0, pci_stop_n};
      default: return {7'b0, desktop};
    endcase
  endfunction

  task automatic expect_at(int k, int sig, logic [7:0] exp, string req);
    item_t it;
    it.due = cyc + k;
    it.sig = sig;
    it.exp = exp;
    it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  // monitor: samples 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    cyc++;
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it  = sb_q.pop_front();
      act = observe(it.sig);
      total++;
      if (it.due != cyc || act !== it.exp) begin
        fails++;
        $display("FAIL %s sig%0d cycle %0d: actual %h expected %h", it.req, it.sig, cyc, act, it.exp);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    por_n = 1'b0;
    pad   = 5'b10110;
    ovr   = 1'b0;
    swfs  = 4'h9;
    // R1: reset state
    expect_at(1, 0, 8'h00, "R1");
    expect_at(1, 1, 8'h00, "R1");
    repeat (3) @(negedge clk);

    // first release: desktop, strap changes one cycle before the freeze
    expect_at(1, 0, 8'h00, "R1");
    expect_at(2, 0, 8'h00, "R5");
    expect_at(2, 1, 8'h00, "R9");
    expect_at(3, 0, 8'h00, "R5");
    expect_at(3, 1, 8'h03, "R8");
    expect_at(3, 2, 8'h0C, "R2");
    expect_at(4, 0, 8'h1F, "R6");
    expect_at(4, 4, 8'h01, "R6");
    expect_at(5, 1, 8'h03, "R3");
    expect_at(5, 2, 8'h0C, "R3");
    expect_at(5, 3, 8'h01, "R7");
    expect_at(5, 4, 8'h01, "R3");
    por_n = 1'b1;
    @(negedge clk);
    pad = 5'b10011;          // still inside the window (R2)
    @(negedge clk);
    pad = 5'b01111;          // after the freeze, must be ignored (R3)
    repeat (4) @(negedge clk);

    // software override toggling (R8)
    ovr = 1'b1;
    expect_at(1, 1, 8'h09, "R8");
    @(negedge clk);
    ovr = 1'b0;
    expect_at(1, 1, 8'h03, "R8");
    @(negedge clk);

    // asynchronous reset in mid-operation (R10)
    por_n = 1'b0;
    pad   = 5'b01010;
    expect_at(1, 0, 8'h00, "R10");
    expect_at(1, 1, 8'h00, "R10");
    expect_at(1, 3, 8'h01, "R7");
    repeat (3) @(negedge clk);

    // second release: mobile, override lands on the first selection load
    expect_at(2, 0, 8'h00, "R5");
    expect_at(3, 1, 8'h07, "R8");
    expect_at(3, 2, 8'h05, "R4");
    expect_at(4, 0, 8'h0F, "R6");
    expect_at(4, 1, 8'h0A, "R8");
    expect_at(4, 4, 8'h00, "R6");
    expect_at(5, 1, 8'h0A, "R3");
    expect_at(5, 2, 8'h05, "R3");
    expect_at(5, 3, 8'h00, "R7");
    expect_at(6, 3, 8'h01, "R7");
    expect_at(6, 4, 8'h00, "R3");
    por_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    ovr  = 1'b1;
    swfs = 4'h7;
    @(negedge clk);
    ovr = 1'b0;
    @(negedge clk);
    pad = 5'b00000;
    @(negedge clk);
    pad = 5'b10000;
    repeat (4) @(negedge clk);

    total++;
    if (sb_q.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    summary();
    $finish;
  end
endmodule